// File: doc/BRIEF.md
# Flash Segment Software Write-Lock Guard

This block sits in front of the programming logic of a flash card. The card is built from several flash segments. Every write cycle headed for the array arrives with a segment index, a device-side address and a data byte. Each segment has its own small state machine. It looks for keyed command sequences in the writes sent to that segment, and it keeps a software lock flag for that segment.

Two sequences are recognised. The three-write arm sequence turns the lock on and opens one programming burst. The six-write release sequence turns the lock off. While a segment is locked, ordinary data writes are dropped unless a burst is open. A burst stays open until the programming logic reports that the segment's load has finished. After that, a fresh arm sequence is needed.

Writes that the guard accepts come out one cycle later on a registered programming port. The lock flag and the burst flag of every segment are visible as vectors. Mapping card addresses onto segment indices and device addresses is done upstream. The sector programmer sits downstream.

Top module: `swp_guard`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every lock flag and burst flag is 0, `prog_valid` is 0, and every segment's sequence tracker is back at its start.
- R2: An accepted write on `wr_*` appears on `prog_valid`/`prog_seg`/`prog_addr`/`prog_data` one clock later, with the same segment, address and data.
- R3: On one segment, the three writes 0xAA at 0x5555, 0x55 at 0x2AAA and 0xA0 at 0x5555, with no other write to that segment between them, set that segment's lock flag and its burst flag.
- R4: A write consumed as a matching step of either command sequence is never forwarded.
- R5: A data write to a locked segment with no open burst is dropped and does not appear on the programming port.
- R6: While a segment's burst is open, every write to it is forwarded and none is decoded as a command, including 0xAA at 0x5555.
- R7: A pulse on `load_done[i]` clears the burst flag of segment i, and later data writes to a locked segment are dropped again.
- R8: Each segment tracks only the writes addressed to it. Writes to other segments may be interleaved inside its sequence without breaking it, and the lock state of one segment never changes another's.
- R9: A write that does not match the next expected step returns that segment's tracker to its start. That write is forwarded only when the segment is unlocked. An unlocked segment's consumed first step (0xAA at 0x5555) is not forwarded.
- R10: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clear that segment's lock flag. The first two steps are shared with the arm sequence, and the branch happens at the third.
- R11: Only the low 15 bits of the device address take part in the command-address comparison. Higher bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A write cycle is present this clock |
| wr_seg | input | SEG_W (3) | Target segment index |
| wr_addr | input | DEV_AW (17) | Device-side byte address |
| wr_data | input | 8 | Write data byte |
| load_done | input | NSEG (8) | Per-segment pulse: programming burst finished |
| prog_valid | output | 1 | Forwarded write present |
| prog_seg | output | SEG_W (3) | Segment of forwarded write |
| prog_addr | output | DEV_AW (17) | Address of forwarded write |
| prog_data | output | 8 | Data of forwarded write |
| prot_o | output | NSEG (8) | Per-segment lock flag |
| open_o | output | NSEG (8) | Per-segment burst-open flag |

## Verification
A tracker left in the wrong step shows up at the ports at the very next write to that segment. If it is stuck mid-sequence, a plain data write to an unlocked segment goes missing from `prog_valid`. If it skips a step, a lock or burst flag changes one write early. A lock flag that is wrong appears on `prot_o` in the cycle after the completing write, and on the programming port when the next data write is wrongly dropped or wrongly passed. The scoreboard flags both missing and unexpected forwarded writes within one cycle.

// File: rtl/swp_pkg.sv
package swp_pkg;

  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] KEY_ADDR_HI = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_LO = 15'h2AAA;

  localparam logic [7:0] KEY_OPEN  = 8'hAA;
  localparam logic [7:0] KEY_CONF  = 8'h55;
  localparam logic [7:0] KEY_ARM   = 8'hA0;
  localparam logic [7:0] KEY_ERASE = 8'h80;
  localparam logic [7:0] KEY_FREE  = 8'h20;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_K1   = 3'd1,
    SQ_K2   = 3'd2,
    SQ_D3   = 3'd3,
    SQ_D4   = 3'd4,
    SQ_D5   = 3'd5
  } seq_t;

  typedef struct packed {
    logic k_open;
    logic k_conf;
    logic k_arm;
    logic k_erase;
    logic k_free;
  } key_t;

endpackage

// File: rtl/swp_key_match.sv
module swp_key_match
  import swp_pkg::*;
(
  input  logic [CMD_AW-1:0] addr,
  input  logic [7:0]        data,
  output key_t              key
);

  logic at_hi;
  logic at_lo;

  assign at_hi = (addr == KEY_ADDR_HI);
  assign at_lo = (addr == KEY_ADDR_LO);

  always_comb begin
    key.k_open  = at_hi && (data == KEY_OPEN);
    key.k_conf  = at_lo && (data == KEY_CONF);
    key.k_arm   = at_hi && (data == KEY_ARM);
    key.k_erase = at_hi && (data == KEY_ERASE);
    key.k_free  = at_hi && (data == KEY_FREE);
  end

endmodule

// File: rtl/swp_seg_sel.sv
module swp_seg_sel #(
  parameter int NSEG  = 8,
  parameter int SEG_W = 3
) (
  input  logic             valid,
  input  logic [SEG_W-1:0] seg,
  output logic [NSEG-1:0]  hit
);

  for (genvar g = 0; g < NSEG; g++) begin : g_hit
    assign hit[g] = valid && (seg == SEG_W'(g));
  end

endmodule

// File: rtl/swp_seg_fsm.sv
module swp_seg_fsm
  import swp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  key_t key,
  input  logic done,
  output logic pass,
  output logic prot_q,
  output logic open_q
);

  seq_t st_q, st_n;
  logic prot_n, open_n;

  always_comb begin
    st_n   = st_q;
    prot_n = prot_q;
    open_n = open_q;
    pass   = 1'b0;
    if (hit) begin
      if (open_q) begin
        pass = 1'b1;
      end else begin
        case (st_q)
          SQ_IDLE: begin
            if (key.k_open) st_n = SQ_K1;
            else            pass = !prot_q;
          end
          SQ_K1: begin
            if (key.k_conf) begin
              st_n = SQ_K2;
            end else begin
              st_n = SQ_IDLE;
              pass = !prot_q;
            end
          end
          SQ_K2: begin
            if (key.k_arm) begin
              st_n   = SQ_IDLE;
              prot_n = 1'b1;
              open_n = 1'b1;
            end else if (key.k_erase) begin
              st_n = SQ_D3;
            end else begin
              st_n = SQ_IDLE;
              pass = !prot_q;
            end
          end
          SQ_D3: begin
            if (key.k_open) begin
              st_n = SQ_D4;
            end else begin
              st_n = SQ_IDLE;
              pass = !prot_q;
            end
          end
          SQ_D4: begin
            if (key.k_conf) begin
              st_n = SQ_D5;
            end else begin
              st_n = SQ_IDLE;
              pass = !prot_q;
            end
          end
          SQ_D5: begin
            st_n = SQ_IDLE;
            if (key.k_free) begin
              prot_n = 1'b0;
              open_n = 1'b0;
            end else begin
              pass = !prot_q;
            end
          end
          default: st_n = SQ_IDLE;
        endcase
      end
    end
    if (done) open_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      prot_q <= 1'b0;
      open_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      prot_q <= prot_n;
      open_q <= open_n;
    end
  end

endmodule

// File: rtl/swp_out_reg.sv
module swp_out_reg #(
  parameter int SEG_W  = 3,
  parameter int DEV_AW = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [SEG_W-1:0]  seg,
  input  logic [DEV_AW-1:0] addr,
  input  logic [7:0]        data,
  output logic              o_valid,
  output logic [SEG_W-1:0]  o_seg,
  output logic [DEV_AW-1:0] o_addr,
  output logic [7:0]        o_data
);

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else     o_valid <= take;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      o_seg  <= seg;
      o_addr <= addr;
      o_data <= data;
    end
  end

endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter  int NSEG   = 8,
  parameter  int DEV_AW = 17,
  localparam int SEG_W  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic [DEV_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NSEG-1:0]   load_done,
  output logic              prog_valid,
  output logic [SEG_W-1:0]  prog_seg,
  output logic [DEV_AW-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic [NSEG-1:0]   prot_o,
  output logic [NSEG-1:0]   open_o
);

  key_t            key;
  logic [NSEG-1:0] hit;
  logic [NSEG-1:0] pass;

  swp_key_match u_key (
    .addr (wr_addr[CMD_AW-1:0]),
    .data (wr_data),
    .key  (key)
  );

  swp_seg_sel #(.NSEG(NSEG), .SEG_W(SEG_W)) u_sel (
    .valid (wr_valid),
    .seg   (wr_seg),
    .hit   (hit)
  );

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    swp_seg_fsm u_fsm (
      .clk    (clk),
      .rst    (rst),
      .hit    (hit[g]),
      .key    (key),
      .done   (load_done[g]),
      .pass   (pass[g]),
      .prot_q (prot_o[g]),
      .open_q (open_o[g])
    );
  end

  swp_out_reg #(.SEG_W(SEG_W), .DEV_AW(DEV_AW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .take    (|pass),
    .seg     (wr_seg),
    .addr    (wr_addr),
    .data    (wr_data),
    .o_valid (prog_valid),
    .o_seg   (prog_seg),
    .o_addr  (prog_addr),
    .o_data  (prog_data)
  );

endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk #(
  parameter int NSEG  = 8,
  parameter int SEG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic [SEG_W-1:0] wr_seg,
  input logic [7:0]       wr_data,
  input logic             prog_valid,
  input logic [SEG_W-1:0] prog_seg,
  input logic [7:0]       prog_data,
  input logic [NSEG-1:0]  prot_o,
  input logic [NSEG-1:0]  open_o
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (prot_o == '0 && open_o == '0 && !prog_valid));

  p_fwd_source_r2: assert property (@(posedge clk) disable iff (rst)
    prog_valid |-> ($past(wr_valid) && prog_seg == $past(wr_seg)
                    && prog_data == $past(wr_data)));

  p_lock_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (|(prot_o & ~$past(prot_o))) |-> $past(wr_valid && wr_data == 8'hA0));

  p_locked_drop_r5: assert property (@(posedge clk) disable iff (rst)
    prog_valid |-> $past(!prot_o[wr_seg] || open_o[wr_seg]));

  p_lock_fall_r10: assert property (@(posedge clk) disable iff (rst)
    (|(~prot_o & $past(prot_o))) |-> $past(wr_valid && wr_data == 8'h20));

endmodule

bind swp_guard swp_guard_chk #(.NSEG(NSEG), .SEG_W(SEG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_seg     (wr_seg),
  .wr_data    (wr_data),
  .prog_valid (prog_valid),
  .prog_seg   (prog_seg),
  .prog_data  (prog_data),
  .prot_o     (prot_o),
  .open_o     (open_o)
);

// File: tb/swp_guard_tb.sv
module swp_guard_tb;

  localparam int NSEG = 8;
  localparam int AW   = 17;
  localparam int SW   = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [SW-1:0] wr_seg = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [NSEG-1:0] load_done = '0;
  logic          prog_valid;
  logic [SW-1:0] prog_seg;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic [NSEG-1:0] prot_o, open_o;

  typedef struct {
    logic [SW-1:0] seg;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    string         tag;
  } item_t;

  item_t sb_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done_f = 0;

  always #2 clk = ~clk;

  swp_guard #(.NSEG(NSEG), .DEV_AW(AW)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_seg(wr_seg),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_done(load_done),
    .prog_valid(prog_valid), .prog_seg(prog_seg), .prog_addr(prog_addr),
    .prog_data(prog_data), .prot_o(prot_o), .open_o(open_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int seg, input int addr, input int data,
                    input bit expect_fwd, input string tag);
    item_t it;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_seg   = SW'(seg);
    wr_addr  = AW'(addr);
    wr_data  = 8'(data);
    if (expect_fwd) begin
      it.seg = SW'(seg); it.addr = AW'(addr); it.data = 8'(data); it.tag = tag;
      sb_q.push_back(it);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b0;
    end
  endtask

  task automatic arm(input int seg, input int hi);
    wr(seg, hi | 'h5555, 'hAA, 0, "R4");
    wr(seg, hi | 'h2AAA, 'h55, 0, "R4");
    wr(seg, hi | 'h5555, 'hA0, 0, "R4");
  endtask

  task automatic release_seq(input int seg);
    wr(seg, 'h5555, 'hAA, 0, "R4");
    wr(seg, 'h2AAA, 'h55, 0, "R4");
    wr(seg, 'h5555, 'h80, 0, "R4");
    wr(seg, 'h5555, 'hAA, 0, "R4");
    wr(seg, 'h2AAA, 'h55, 0, "R4");
    wr(seg, 'h5555, 'h20, 0, "R4");
  endtask

  task automatic finish_done(input int seg);
    @(negedge clk);
    wr_valid  = 1'b0;
    load_done = NSEG'(1) << seg;
    @(negedge clk);
    load_done = '0;
  endtask

  task automatic drained(input string tag);
    idle(2);
    chk(sb_q.size() == 0, tag, sb_q.size(), 0);
  endtask

  // monitor: compares forwarded writes against the scoreboard queue
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && prog_valid) begin
        if (sb_q.size() == 0) begin
          chk(0, "R5 unexpected forward", int'(prog_data), 0);
        end else begin
          item_t e;
          e = sb_q.pop_front();
          chk(prog_seg == e.seg && prog_addr == e.addr && prog_data == e.data,
              {e.tag, " R2 forwarded write"},
              int'({prog_seg, prog_addr, prog_data}), int'({e.seg, e.addr, e.data}));
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done_f) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(prot_o == '0, "R1 prot after reset", int'(prot_o), 0);
    chk(open_o == '0, "R1 open after reset", int'(open_o), 0);
    chk(!prog_valid, "R1 prog_valid in reset", int'(prog_valid), 0);
    rst = 1'b0;
    idle(2);

    // R2: unlocked segment forwards plain writes
    wr(0, 'h0010, 'h3C, 1, "R2");
    wr(7, 'h1F00F, 'hC3, 1, "R2");
    drained("R2 drain");

    // R3/R4: arm segment 2
    arm(2, 0);
    idle(1);
    chk(prot_o[2] == 1'b1, "R3 lock set", int'(prot_o[2]), 1);
    chk(open_o[2] == 1'b1, "R3 burst open", int'(open_o[2]), 1);
    chk(prot_o == 8'h04, "R8 only seg2 locked", int'(prot_o), 'h04);
    drained("R4 commands consumed");

    // R6: burst forwards everything, including a key pattern
    wr(2, 'h0100, 'h11, 1, "R6");
    wr(2, 'h5555, 'hAA, 1, "R6");
    wr(2, 'h2AAA, 'h55, 1, "R6");
    drained("R6 drain");

    // R7: load_done closes burst
    finish_done(2);
    chk(open_o[2] == 1'b0, "R7 burst closed", int'(open_o[2]), 0);
    chk(prot_o[2] == 1'b1, "R7 lock kept", int'(prot_o[2]), 1);
    wr(2, 'h0101, 'h22, 0, "R5");
    wr(0, 'h0101, 'h23, 1, "R8");
    drained("R5 locked drop");

    // R9: mismatch on locked segment resets tracker, write dropped
    wr(2, 'h5555, 'hAA, 0, "R9");
    wr(2, 'h0100, 'h12, 0, "R9");
    wr(2, 'h2AAA, 'h55, 0, "R9");
    wr(2, 'h5555, 'hA0, 0, "R9");
    idle(1);
    chk(open_o[2] == 1'b0, "R9 restart needed", int'(open_o[2]), 0);
    drained("R9 locked mismatch");

    // R9: mismatch on unlocked segment forwards only the mismatching write
    wr(0, 'h5555, 'hAA, 0, "R9");
    wr(0, 'h0123, 'h77, 1, "R9");
    wr(0, 'h0124, 'h78, 1, "R9");
    drained("R9 unlocked mismatch");

    // R8: interleaved arm of seg5 with traffic to seg0
    wr(5, 'h5555, 'hAA, 0, "R8");
    wr(0, 'h0010, 'h01, 1, "R8");
    wr(5, 'h2AAA, 'h55, 0, "R8");
    wr(0, 'h0011, 'h02, 1, "R8");
    wr(5, 'h5555, 'hA0, 0, "R8");
    idle(1);
    chk(prot_o[5] && open_o[5], "R8 seg5 armed", int'({prot_o[5], open_o[5]}), 3);
    chk(prot_o[0] == 1'b0, "R8 seg0 unlocked", int'(prot_o[0]), 0);
    wr(5, 'h0200, 'h33, 1, "R8");
    drained("R8 drain");

    // R10: release seg2
    release_seq(2);
    idle(1);
    chk(prot_o[2] == 1'b0, "R10 lock cleared", int'(prot_o[2]), 0);
    chk(prot_o[5] == 1'b1, "R10 seg5 untouched", int'(prot_o[5]), 1);
    wr(2, 'h0300, 'h44, 1, "R10");
    drained("R10 drain");

    // R11: upper address bits ignored in key compare
    arm(6, 'h10000);
    idle(1);
    chk(prot_o[6] && open_o[6], "R11 high bits ignored", int'({prot_o[6], open_o[6]}), 3);
    drained("R11 drain");

    // R1: reset mid-operation
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    chk(prot_o == '0 && open_o == '0, "R1 reset clears", int'({prot_o, open_o}), 0);
    rst = 1'b0;
    wr(5, 'h0001, 'h99, 1, "R1");
    drained("R1 after reset");

    done_f = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule